// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours, a day-of-week index, day-of-month, month with a century bit, and a two-digit year. A one-cycle `tick_en` pulse at 32.768 kHz drives an internal binary divider. That divider produces a 2 Hz phase, a 1 Hz phase and, a few ticks after each 1 Hz falling edge, the request to advance the seconds. Hours run in either 12-hour form (an AM/PM flag in bit 5) or 24-hour form, as selected by `mode_24h`. Software must set that pin before it loads the time, because the hour register is not converted when the mode changes.

A carry sequencer moves each increment through the fields, one field per clock cycle. Its states are `ST_IDLE`, `ST_LAG`, `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DAY`, `ST_MON` and `ST_YEAR`. The transitions are:

- **ST_IDLE to ST_LAG** when the divider wraps.
- **ST_LAG to ST_SEC** on the `LAG_TICKS`-th tick after the wrap.
- **Carry steps**: each field state moves to the next field state only when its own field wraps (in the 12-hour form the hour carries only at 11 PM). Otherwise it returns to `ST_IDLE`.
- **ST_YEAR to ST_IDLE** always.
- **Seconds write**: a write to the seconds field forces `ST_IDLE` from any state.

The sequencer also emits one-cycle strobes on each second advance and on each field rollover. Interrupt logic can use these strobes. A plain register port with a shared address lets software load any field and read it back.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read as follows: seconds 0x00, minutes 0x00, day-of-week 0x00, day-of-month 0x01, month 0x01 with the century bit clear, and year 0x00. The hour reads 0x12 if `mode_24h` is 0 during reset, or 0x00 if it is 1. All strobes are low.
- R2: After a write to the seconds field, the seconds advance on the (2^DIV_W + LAG_TICKS)-th tick counted from that write, and then every 2^DIV_W ticks. A seconds write clears the divider.
- R3: Seconds (address 0) and minutes (address 1) count in BCD from 00 to 59. On 59 they wrap to 00 and carry into the next field. `sec_stb` pulses on every second advance, `min_stb` pulses when seconds wrap, and `hour_stb` pulses when minutes wrap.
- R4: When `mode_24h` is 1, the hour (address 2) counts from 0x00 to 0x23 in BCD. The step from 0x23 to 0x00 carries into the day and pulses `day_stb`.
- R5: When `mode_24h` is 0, bit 5 of the hour is the PM flag. The hour steps 0x11 to 0x32 with no day carry, 0x12 to 0x01, 0x32 to 0x21, and 0x29 to 0x30. The step 0x31 to 0x12 carries into the day and pulses `day_stb`.
- R6: Day-of-week (address 3, bits 2:0) advances on every day carry and wraps from 6 to 0.
- R7: Day-of-month (address 4) wraps to 0x01 after its last day and pulses `month_stb`. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for every other month except February. February ends at 0x29 when the BCD year is a multiple of 4 (00 included) and at 0x28 otherwise. Month (address 5, bits 4:0) wraps from 0x12 to 0x01 and carries into the year.
- R8: Year (address 6) counts 0x00 to 0x99 in BCD. The step from 0x99 to 0x00 toggles the century bit, which is bit 7 of the month field.
- R9: Bits without a function read 0 and ignore writes. The write masks are 0x7F for seconds, 0x7F for minutes, 0x3F for hour, 0x07 for day-of-week, 0x3F for day-of-month, 0x9F for month and 0xFF for year. Address 7 reads 0x00.
- R10: `ph_1hz` is low for the first half of each divider period and high for the second half, so it falls when the divider wraps. `ph_2hz` completes two such cycles per period. Both phases restart low on a seconds write.
- R11: Each strobe is high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| mode_24h | input | 1 | 1 selects the 24-hour form, 0 selects the 12-hour form |
| wr_en | input | 1 | Write strobe for the field at `addr` |
| addr | input | 3 | Field address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Field contents at `addr` (combinational) |
| ph_2hz | output | 1 | 2 Hz phase |
| ph_1hz | output | 1 | 1 Hz phase |
| sec_stb | output | 1 | Pulses on each second advance |
| min_stb | output | 1 | Pulses when seconds wrap |
| hour_stb | output | 1 | Pulses when minutes wrap |
| day_stb | output | 1 | Pulses on a day carry |
| month_stb | output | 1 | Pulses when day-of-month wraps to 01 |

## Verification
The bench targets the following corners and the failures they expose:

- **Increment timing after a seconds write.** A design that skips the post-wrap lag, or that fails to clear the divider on the write, advances one or more ticks early or late.
- **The 12-hour sequence.** A design that confuses the 11 AM step with the 11 PM step carries a day at noon or never at midnight. A design that mishandles 12 o'clock produces 0x13 or 0x00.
- **The calendar ends.** The bench walks February in years 00, 10, 12, 23 and 24, the 30-day months, December, and the 99 rollover. A wrong leap rule or wrong month lengths shows up as a day 29, 30 or 31 that should not exist, or as a missing one.
- **The century toggle.** A design that sets the century bit instead of toggling it leaves the bit set on the second rollover.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAG,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MON,
        ST_YEAR
    } rtc_state_e;

    localparam logic [2:0] A_SEC   = 3'd0;
    localparam logic [2:0] A_MIN   = 3'd1;
    localparam logic [2:0] A_HOUR  = 3'd2;
    localparam logic [2:0] A_DOW   = 3'd3;
    localparam logic [2:0] A_DOM   = 3'd4;
    localparam logic [2:0] A_MONTH = 3'd5;
    localparam logic [2:0] A_YEAR  = 3'd6;

    // Adds one to a two-digit packed BCD value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) begin
            bcd_inc = {v[7:4] + 4'd1, 4'd0};
        end else begin
            bcd_inc = {v[7:4], v[3:0] + 4'd1};
        end
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic restart,
    output logic wrap_o,
    output logic ph_1hz_o,
    output logic ph_2hz_o
);
    localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wrap_o   = tick_en && !restart && (cnt_q == CNT_MAX);
    assign ph_1hz_o = cnt_q[DIV_W-1];
    assign ph_2hz_o = cnt_q[DIV_W-2];
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_dom
);
    logic leap;

    // A BCD year is a multiple of 4 when (odd tens, ones 2/6) or (even tens, ones 0/4/8).
    always_comb begin
        if (year[4]) begin
            leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        end else begin
            leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        end
    end

    always_comb begin
        unique case (month)
            5'h02:                      last_dom = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_dom = 8'h30;
            default:                    last_dom = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int LAG_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       mode_24h,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       ph_2hz,
    output logic       ph_1hz,
    output logic       sec_stb,
    output logic       min_stb,
    output logic       hour_stb,
    output logic       day_stb,
    output logic       month_stb
);
    localparam int LAG_W = $clog2(LAG_TICKS + 1);
    localparam logic [LAG_W-1:0] LAG_LAST = LAG_W'(LAG_TICKS - 1);

    rtc_state_e state_q, state_d;
    logic [LAG_W-1:0] lag_q;
    logic [7:0] sec_q, min_q, hour_q, dow_q, dom_q, month_q, year_q;
    logic [7:0] hour_nxt, last_dom, hinc;
    logic       sec_wr, wrap, day_carry;

    assign sec_wr = wr_en && (addr == A_SEC);

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .restart  (sec_wr),
        .wrap_o   (wrap),
        .ph_1hz_o (ph_1hz),
        .ph_2hz_o (ph_2hz)
    );

    rtc_month_len u_mlen (
        .month    (month_q[4:0]),
        .year     (year_q),
        .last_dom (last_dom)
    );

    // Hour step for both modes; 12-hour form keeps the PM flag in bit 5.
    always_comb begin
        hinc = bcd_inc({3'b000, hour_q[4:0]});
        if (mode_24h) begin
            day_carry = (hour_q == 8'h23);
            hour_nxt  = day_carry ? 8'h00 : bcd_inc(hour_q);
        end else begin
            day_carry = (hour_q == 8'h31);
            if (hour_q[4:0] == 5'h11) begin
                hour_nxt = {2'b00, ~hour_q[5], 5'h12};
            end else if (hour_q[4:0] == 5'h12) begin
                hour_nxt = {2'b00, hour_q[5], 5'h01};
            end else begin
                hour_nxt = {2'b00, hour_q[5], hinc[4:0]};
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && wrap) begin
                lag_q <= '0;
            end else if (state_q == ST_LAG && tick_en) begin
                lag_q <= lag_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = wrap ? ST_LAG : ST_IDLE;
            ST_LAG:  state_d = (tick_en && lag_q == LAG_LAST) ? ST_SEC : ST_LAG;
            ST_SEC:  state_d = (sec_q == 8'h59) ? ST_MIN : ST_IDLE;
            ST_MIN:  state_d = (min_q == 8'h59) ? ST_HOUR : ST_IDLE;
            ST_HOUR: state_d = day_carry ? ST_DAY : ST_IDLE;
            ST_DAY:  state_d = (dom_q == last_dom) ? ST_MON : ST_IDLE;
            ST_MON:  state_d = (month_q[4:0] == 5'h12) ? ST_YEAR : ST_IDLE;
            ST_YEAR: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (sec_wr) state_d = ST_IDLE;
    end

    // Field registers and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= 8'h00;
            min_q   <= 8'h00;
            hour_q  <= mode_24h ? 8'h00 : 8'h12;
            dow_q   <= 8'h00;
            dom_q   <= 8'h01;
            month_q <= 8'h01;
            year_q  <= 8'h00;
            sec_stb <= 1'b0;
            min_stb <= 1'b0;
            hour_stb  <= 1'b0;
            day_stb   <= 1'b0;
            month_stb <= 1'b0;
        end else begin
            sec_stb   <= 1'b0;
            min_stb   <= 1'b0;
            hour_stb  <= 1'b0;
            day_stb   <= 1'b0;
            month_stb <= 1'b0;
            unique case (state_q)
                ST_SEC: begin
                    sec_q   <= (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
                    sec_stb <= 1'b1;
                    min_stb <= (sec_q == 8'h59);
                end
                ST_MIN: begin
                    min_q    <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
                    hour_stb <= (min_q == 8'h59);
                end
                ST_HOUR: begin
                    hour_q  <= hour_nxt;
                    day_stb <= day_carry;
                end
                ST_DAY: begin
                    dow_q     <= (dow_q == 8'h06) ? 8'h00 : dow_q + 8'h01;
                    dom_q     <= (dom_q == last_dom) ? 8'h01 : bcd_inc(dom_q);
                    month_stb <= (dom_q == last_dom);
                end
                ST_MON: begin
                    month_q[4:0] <= (month_q[4:0] == 5'h12) ? 5'h01
                                    : bcd_inc({3'b000, month_q[4:0]})[4:0];
                end
                ST_YEAR: begin
                    year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
                    if (year_q == 8'h99) month_q[7] <= ~month_q[7];
                end
                default: ;
            endcase
            if (wr_en) begin
                unique case (addr)
                    A_SEC:   sec_q   <= wr_data & 8'h7F;
                    A_MIN:   min_q   <= wr_data & 8'h7F;
                    A_HOUR:  hour_q  <= wr_data & 8'h3F;
                    A_DOW:   dow_q   <= wr_data & 8'h07;
                    A_DOM:   dom_q   <= wr_data & 8'h3F;
                    A_MONTH: month_q <= wr_data & 8'h9F;
                    A_YEAR:  year_q  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Read mux
    always_comb begin
        unique case (addr)
            A_SEC:   rd_data = sec_q;
            A_MIN:   rd_data = min_q;
            A_HOUR:  rd_data = hour_q;
            A_DOW:   rd_data = dow_q;
            A_DOM:   rd_data = dom_q;
            A_MONTH: rd_data = month_q;
            A_YEAR:  rd_data = year_q;
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_24h,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic [7:0] dom_q,
    input logic       sec_stb,
    input logic       min_stb,
    input logic       hour_stb,
    input logic       day_stb,
    input logic       month_stb
);
    p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb |-> (sec_q <= 8'h59));

    p_min_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        min_stb |-> (sec_stb && sec_q == 8'h00));

    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hour_stb |-> (min_q == 8'h00));

    p_day_hour_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (day_stb && mode_24h) |-> (hour_q == 8'h00));

    p_day_hour_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (day_stb && !mode_24h) |-> (hour_q == 8'h12));

    p_month_dom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        month_stb |-> (dom_q == 8'h01));

    p_sec_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb |=> !sec_stb);

    p_day_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        day_stb |=> !day_stb);
endmodule

bind bcd_rtc_core bcd_rtc_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_24h  (mode_24h),
    .sec_q     (sec_q),
    .min_q     (min_q),
    .hour_q    (hour_q),
    .dom_q     (dom_q),
    .sec_stb   (sec_stb),
    .min_stb   (min_stb),
    .hour_stb  (hour_stb),
    .day_stb   (day_stb),
    .month_stb (month_stb)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 5;
    localparam int LAG_TICKS  = 3;
    localparam int PERIOD     = 1 << DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       mode_24h = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ph_2hz, ph_1hz, sec_stb, min_stb, hour_stb, day_stb, month_stb;

    int n_checks = 0;
    int n_fail   = 0;
    int n_sec = 0, n_min = 0, n_hour = 0, n_day = 0, n_month = 0, n_double = 0;
    logic [4:0] prev_stb = '0;
    logic       mon_go = 1'b0;
    logic [2:0] exp_addr_q[$];
    logic [7:0] exp_data_q[$];
    string      exp_tag_q[$];
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc_core #(.DIV_W(DIV_W), .LAG_TICKS(LAG_TICKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_24h(mode_24h),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .ph_2hz(ph_2hz), .ph_1hz(ph_1hz), .sec_stb(sec_stb), .min_stb(min_stb),
        .hour_stb(hour_stb), .day_stb(day_stb), .month_stb(month_stb)
    );

    // Strobe monitor (R11: single-cycle strobes)
    always @(negedge clk) begin
        if (rst_n) begin
            n_sec   <= n_sec + int'(sec_stb);
            n_min   <= n_min + int'(min_stb);
            n_hour  <= n_hour + int'(hour_stb);
            n_day   <= n_day + int'(day_stb);
            n_month <= n_month + int'(month_stb);
            if ((prev_stb & {sec_stb, min_stb, hour_stb, day_stb, month_stb}) != 5'b0)
                n_double <= n_double + 1;
            prev_stb <= {sec_stb, min_stb, hour_stb, day_stb, month_stb};
        end
    end

    // Scoreboard monitor: pops the expected field value and compares
    always @(negedge clk) begin
        if (mon_go && exp_addr_q.size() > 0) begin
            logic [2:0] a;
            logic [7:0] e;
            string t;
            a = exp_addr_q.pop_front();
            e = exp_data_q.pop_front();
            t = exp_tag_q.pop_front();
            n_checks++;
            if (addr !== a || rd_data !== e) begin
                n_fail++;
                $display("FAIL %s addr %0d: actual %h expected %h", t, a, rd_data, e);
            end
        end
    end

    task automatic check_val(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_addr_q.push_back(a);
        exp_data_q.push_back(e);
        exp_tag_q.push_back(tag);
        @(posedge clk);
        addr   = a;
        mon_go = 1'b1;
        @(posedge clk);
        mon_go = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic first_second();
        ticks(PERIOD + LAG_TICKS);
        settle();
    endtask

    // Load a clock time then advance one second from the seconds write
    task automatic step_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
        first_second();
    endtask

    task automatic roll_day(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
        wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d);
        step_time(8'h23, 8'h59, 8'h59);
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int s0, m0, h0, d0, mo0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, 12-hour mode
        check_val("R1 strobes", n_sec + n_min + n_hour + n_day + n_month, 0);
        expect_reg(3'd0, 8'h00, "R1 sec");
        expect_reg(3'd1, 8'h00, "R1 min");
        expect_reg(3'd2, 8'h12, "R1 hour");
        expect_reg(3'd3, 8'h00, "R1 dow");
        expect_reg(3'd4, 8'h01, "R1 dom");
        expect_reg(3'd5, 8'h01, "R1 month");
        expect_reg(3'd6, 8'h00, "R1 year");

        // R9 masks and unused address
        wr(3'd3, 8'hFD); expect_reg(3'd3, 8'h05, "R9 dow mask");
        wr(3'd2, 8'hD2); expect_reg(3'd2, 8'h12, "R9 hour mask");
        wr(3'd5, 8'hE5); expect_reg(3'd5, 8'h85, "R9 month mask");
        wr(3'd4, 8'hC7); expect_reg(3'd4, 8'h07, "R9 dom mask");
        wr(3'd0, 8'hD5); expect_reg(3'd0, 8'h55, "R9 sec mask");
        wr(3'd7, 8'hAA); expect_reg(3'd7, 8'h00, "R9 addr 7");
        wr(3'd5, 8'h01);

        // R2 / R10 divider phases and increment timing
        s0 = n_sec;
        wr(3'd0, 8'h10);
        check_val("R10 ph_1hz after write", int'(ph_1hz), 0);
        check_val("R10 ph_2hz after write", int'(ph_2hz), 0);
        ticks(PERIOD/4);
        check_val("R10 ph_2hz quarter", int'(ph_2hz), 1);
        check_val("R10 ph_1hz quarter", int'(ph_1hz), 0);
        ticks(PERIOD/4);
        check_val("R10 ph_2hz half", int'(ph_2hz), 0);
        check_val("R10 ph_1hz half", int'(ph_1hz), 1);
        ticks(PERIOD/2);
        check_val("R10 ph_1hz wrap", int'(ph_1hz), 0);
        ticks(LAG_TICKS - 1);
        settle();
        expect_reg(3'd0, 8'h10, "R2 no early advance");
        ticks(1);
        settle();
        expect_reg(3'd0, 8'h11, "R2 advance at lag tick");
        ticks(PERIOD);
        settle();
        expect_reg(3'd0, 8'h12, "R2 next period");
        check_val("R3 sec_stb count", n_sec - s0, 2);

        // R3 minute and hour carries
        m0 = n_min; h0 = n_hour;
        wr(3'd3, 8'h03); wr(3'd4, 8'h15);
        step_time(8'h05, 8'h59, 8'h59);
        expect_reg(3'd0, 8'h00, "R3 sec wrap");
        expect_reg(3'd1, 8'h00, "R3 min wrap");
        expect_reg(3'd2, 8'h06, "R3 hour carry");
        check_val("R3 min_stb", n_min - m0, 1);
        check_val("R3 hour_stb", n_hour - h0, 1);
        step_time(8'h05, 8'h09, 8'h59);
        expect_reg(3'd1, 8'h10, "R3 min BCD carry");
        expect_reg(3'd2, 8'h05, "R3 hour unchanged");

        // R5 12-hour sequence
        d0 = n_day;
        step_time(8'h11, 8'h59, 8'h59);
        expect_reg(3'd2, 8'h32, "R5 11AM to noon");
        expect_reg(3'd3, 8'h03, "R5 no day carry at noon");
        check_val("R5 no day_stb at noon", n_day - d0, 0);
        step_time(8'h32, 8'h59, 8'h59);
        expect_reg(3'd2, 8'h21, "R5 noon to 1PM");
        step_time(8'h12, 8'h59, 8'h59);
        expect_reg(3'd2, 8'h01, "R5 midnight to 1AM");
        step_time(8'h29, 8'h59, 8'h59);
        expect_reg(3'd2, 8'h30, "R5 9PM to 10PM");
        step_time(8'h31, 8'h59, 8'h59);
        expect_reg(3'd2, 8'h12, "R5 11PM to midnight");
        expect_reg(3'd3, 8'h04, "R6 dow advance");
        expect_reg(3'd4, 8'h16, "R5 dom advance");
        check_val("R5 day_stb at midnight", n_day - d0, 1);

        // R4 24-hour mode
        @(negedge clk) mode_24h = 1'b1;
        d0 = n_day;
        step_time(8'h19, 8'h59, 8'h59);
        expect_reg(3'd2, 8'h20, "R4 BCD carry");
        step_time(8'h23, 8'h59, 8'h59);
        expect_reg(3'd2, 8'h00, "R4 wrap");
        check_val("R4 day_stb", n_day - d0, 1);

        // R6 day-of-week wrap
        wr(3'd3, 8'h06);
        roll_day(8'h05, 8'h03, 8'h10);
        expect_reg(3'd3, 8'h00, "R6 dow wrap");

        // R7 month lengths and leap years
        mo0 = n_month;
        roll_day(8'h05, 8'h04, 8'h30);
        expect_reg(3'd4, 8'h01, "R7 April 30 wraps");
        expect_reg(3'd5, 8'h05, "R7 month advance");
        check_val("R7 month_stb", n_month - mo0, 1);
        roll_day(8'h05, 8'h05, 8'h30);
        expect_reg(3'd4, 8'h31, "R7 May has 31");
        roll_day(8'h05, 8'h11, 8'h30);
        expect_reg(3'd5, 8'h12, "R7 November 30 wraps");
        roll_day(8'h24, 8'h02, 8'h28);
        expect_reg(3'd4, 8'h29, "R7 Feb 29 in 24");
        roll_day(8'h00, 8'h02, 8'h28);
        expect_reg(3'd4, 8'h29, "R7 Feb 29 in 00");
        roll_day(8'h12, 8'h02, 8'h28);
        expect_reg(3'd4, 8'h29, "R7 Feb 29 in 12");
        roll_day(8'h23, 8'h02, 8'h28);
        expect_reg(3'd4, 8'h01, "R7 Feb 28 wraps in 23");
        expect_reg(3'd5, 8'h03, "R7 March follows");
        roll_day(8'h10, 8'h02, 8'h28);
        expect_reg(3'd4, 8'h01, "R7 Feb 28 wraps in 10");
        roll_day(8'h24, 8'h02, 8'h29);
        expect_reg(3'd5, 8'h03, "R7 leap Feb 29 wraps");
        roll_day(8'h47, 8'h12, 8'h31);
        expect_reg(3'd5, 8'h01, "R7 December wraps");
        expect_reg(3'd6, 8'h48, "R7 year carry");

        // R8 century toggle
        roll_day(8'h99, 8'h12, 8'h31);
        expect_reg(3'd6, 8'h00, "R8 year wrap");
        expect_reg(3'd5, 8'h81, "R8 century set");
        roll_day(8'h99, 8'h92, 8'h31);
        expect_reg(3'd5, 8'h01, "R8 century toggles back");

        // R11 single-cycle strobes
        check_val("R11 no stretched strobe", n_double, 0);

        settle();
        done = 1'b1;
        report();
    end
endmodule